// File: doc/BRIEF.md
# Band-Interleaved Plane Pair Grabber

This block takes in a hyperspectral cube that arrives one 16-bit sample per accepted beat, in band-interleaved-by-line order. Within a row the column index runs fastest, then the band index, and one full row across all bands forms a horizontal plane. For every sample it accepts, the block writes the sample into an on-chip plane store. In the same access it reads back the value that the previous plane left at the same column and band. It then presents the pair to a downstream prediction stage over a valid/ready interface.

The plane store holds one full plane. Its words are addressed as `band * MAX_COLS + column`, the same layout an external memory would use. The read of the old word and the write of the new one happen in a single read-first access, so one port is enough. On the first plane of a cube no previous plane exists, and the previous value is forced to 0x0000. The column, band and row counts are set at run time. A start pulse begins a new cube. A row count of zero means the cube has no end.

Top module: `plane_pair_grabber`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1, and the first sample accepted is treated as column 0, band 0 of the first plane of a cube.
- R2: Every accepted input sample appears exactly once on `outCur`, in the order it was accepted. No sample is dropped or duplicated.
- R3: Outside the first plane, `outPrev` equals the sample accepted at the same column and band in the previous plane. The position order is column fastest (0 to `cfgCols`-1), then band (0 to `cfgBands`-1), then row.
- R4: For every sample of the first plane of a cube, `outFirstPlane` is 1 and `outPrev` is 0x0000. On all later planes `outFirstPlane` is 0.
- R5: `outEndPlane` is 1 exactly for the sample at column `cfgCols`-1 of band `cfgBands`-1.
- R6: When `cfgRows` is nonzero, `outEndCube` is 1 exactly for the end-of-plane sample of row `cfgRows`-1. The sample accepted after it starts a new cube at its first plane.
- R7: When `cfgRows` is 0, `outEndCube` is never set, and only the first plane after a start pulse or reset is flagged as first.
- R8: While `outValid` is 1 and `outReady` is 0, `inReady` is 0, and `outCur`, `outPrev` and all three flags hold their values.
- R9: In a cycle with `startCube` at 1, `inReady` is 0. The next accepted sample is column 0, band 0 of a new first plane, and an output already pending is kept.
- R10: A sample accepted at a clock edge is valid at the output right after that edge. With `outReady` held at 1 and no start pulse, `inReady` stays 1, which gives one sample per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCols | input | $clog2(MAX_COLS+1) | Columns per band line, 1 to MAX_COLS |
| cfgBands | input | $clog2(MAX_BANDS+1) | Bands per plane, 1 to MAX_BANDS |
| cfgRows | input | ROW_W | Rows per cube; 0 means no end |
| startCube | input | 1 | One-cycle pulse that begins a new cube |
| inValid | input | 1 | Input sample valid |
| inData | input | SAMPLE_W | Input sample |
| inReady | output | 1 | Input sample accepted when high with inValid |
| outValid | output | 1 | Output pair valid |
| outReady | input | 1 | Downstream takes the pair |
| outCur | output | SAMPLE_W | Current sample |
| outPrev | output | SAMPLE_W | Co-located sample of the previous plane, or 0 |
| outFirstPlane | output | 1 | Pair belongs to the first plane of a cube |
| outEndPlane | output | 1 | Last sample of a plane |
| outEndCube | output | 1 | Last sample of the cube |

## Verification
The bench builds the block with MAX_COLS=8, MAX_BANDS=4 and ROW_W=4, so the whole store has 32 words. At that size a full plane, a cube of several rows and the largest configured shape (8 columns by 4 bands) all fit in short runs, and every wrap point of the column, band and row counters is reached many times. The runs also cover a store reused after a shape change, a start pulse in the middle of a plane while an output is stalled, a one-by-one plane, and an unbounded cube. Random backpressure and input gaps are used throughout.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  // Strobes from the control to the datapath for one accepted beat.
  typedef struct packed {
    logic load;      // accept the present input sample
    logic zeroPrev;  // the accepted sample belongs to a first plane
  } ppg_strobe_t;
endpackage

// File: rtl/ppg_plane_store.sv
// One-port plane store. Read-first: the old word is registered, then the new word overwrites it.
module ppg_plane_store #(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 1024,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SAMPLE_W-1:0] wrData,
  output logic [SAMPLE_W-1:0] rdData
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [SAMPLE_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (en) begin
      rdQ       <= mem[addr];
      mem[addr] <= wrData;
    end
  end

  assign rdData = rdQ;
endmodule

// File: rtl/ppg_ctrl.sv
module ppg_ctrl import ppg_pkg::*; #(
  parameter int MAX_COLS  = 32,
  parameter int MAX_BANDS = 32,
  parameter int ROW_W     = 16,
  localparam int COL_W    = $clog2(MAX_COLS + 1),
  localparam int BAND_W   = $clog2(MAX_BANDS + 1),
  localparam int COLI_W   = $clog2(MAX_COLS),
  localparam int BANDI_W  = $clog2(MAX_BANDS),
  localparam int DEPTH    = MAX_COLS * MAX_BANDS,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [COL_W-1:0]  cfgCols,
  input  logic [BAND_W-1:0] cfgBands,
  input  logic [ROW_W-1:0]  cfgRows,
  input  logic              startCube,
  input  logic              inValid,
  output logic              inReady,
  input  logic              outReady,
  output logic              outValid,
  output logic              outFirstPlane,
  output logic              outEndPlane,
  output logic              outEndCube,
  output ppg_strobe_t       strobe,
  output logic [ADDR_W-1:0] addr
);
  logic [COLI_W-1:0]  colQ;
  logic [BANDI_W-1:0] bandQ;
  logic [ROW_W-1:0]   rowQ;
  logic               firstPlaneQ;
  logic               outValidQ;
  logic               firstQ, endPlaneQ, endCubeQ;

  logic accept, lastCol, lastBand, lastRow, endPlane, endCube;

  assign inReady  = (!outValidQ || outReady) && !startCube;
  assign accept   = inValid && inReady;
  assign lastCol  = COL_W'(colQ) == cfgCols - COL_W'(1);
  assign lastBand = BAND_W'(bandQ) == cfgBands - BAND_W'(1);
  assign lastRow  = (cfgRows != '0) && (rowQ == cfgRows - ROW_W'(1));
  assign endPlane = lastCol && lastBand;
  assign endCube  = endPlane && lastRow;

  assign addr = ADDR_W'(bandQ) * ADDR_W'(MAX_COLS) + ADDR_W'(colQ);

  always_comb begin
    strobe          = '0;
    strobe.load     = accept;
    strobe.zeroPrev = firstPlaneQ;
  end

  // Position counters: column fastest, then band, then row.
  always_ff @(posedge clk) begin
    if (!rstN || startCube) begin
      colQ        <= '0;
      bandQ       <= '0;
      rowQ        <= '0;
      firstPlaneQ <= 1'b1;
    end else if (accept) begin
      if (!lastCol) begin
        colQ <= colQ + COLI_W'(1);
      end else begin
        colQ <= '0;
        if (!lastBand) begin
          bandQ <= bandQ + BANDI_W'(1);
        end else begin
          bandQ <= '0;
          if (lastRow) begin
            rowQ        <= '0;
            firstPlaneQ <= 1'b1;
          end else begin
            rowQ        <= rowQ + ROW_W'(1);
            firstPlaneQ <= 1'b0;
          end
        end
      end
    end
  end

  // Output stage valid and flags.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      firstQ    <= 1'b0;
      endPlaneQ <= 1'b0;
      endCubeQ  <= 1'b0;
    end else if (accept) begin
      outValidQ <= 1'b1;
      firstQ    <= firstPlaneQ;
      endPlaneQ <= endPlane;
      endCubeQ  <= endCube;
    end else if (outReady) begin
      outValidQ <= 1'b0;
    end
  end

  assign outValid      = outValidQ;
  assign outFirstPlane = firstQ;
  assign outEndPlane   = endPlaneQ;
  assign outEndCube    = endCubeQ;

  assert_block_in_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValidQ && !outReady) |-> !inReady);

  assert_start_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    startCube |-> !inReady);

  assert_start_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    startCube |=> (firstPlaneQ && colQ == '0 && bandQ == '0 && rowQ == '0));

  assert_col_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!startCube && cfgCols != '0 && cfgBands != '0) |->
      (COL_W'(colQ) < cfgCols && BAND_W'(bandQ) < cfgBands));
endmodule

// File: rtl/ppg_datapath.sv
module ppg_datapath import ppg_pkg::*; #(
  parameter int SAMPLE_W  = 16,
  parameter int MAX_COLS  = 32,
  parameter int MAX_BANDS = 32,
  localparam int DEPTH    = MAX_COLS * MAX_BANDS,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ppg_strobe_t         strobe,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SAMPLE_W-1:0] inData,
  output logic [SAMPLE_W-1:0] outCur,
  output logic [SAMPLE_W-1:0] outPrev
);
  logic [SAMPLE_W-1:0] curQ;
  logic [SAMPLE_W-1:0] storeQ;
  logic                zeroQ;

  ppg_plane_store #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .en     (strobe.load),
    .addr   (addr),
    .wrData (inData),
    .rdData (storeQ)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curQ  <= '0;
      zeroQ <= 1'b1;
    end else if (strobe.load) begin
      curQ  <= inData;
      zeroQ <= strobe.zeroPrev;
    end
  end

  assign outCur  = curQ;
  assign outPrev = zeroQ ? '0 : storeQ;
endmodule

// File: rtl/plane_pair_grabber.sv
module plane_pair_grabber import ppg_pkg::*; #(
  parameter int SAMPLE_W  = 16,
  parameter int MAX_COLS  = 32,
  parameter int MAX_BANDS = 32,
  parameter int ROW_W     = 16,
  localparam int COL_W    = $clog2(MAX_COLS + 1),
  localparam int BAND_W   = $clog2(MAX_BANDS + 1),
  localparam int ADDR_W   = $clog2(MAX_COLS * MAX_BANDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [COL_W-1:0]    cfgCols,
  input  logic [BAND_W-1:0]   cfgBands,
  input  logic [ROW_W-1:0]    cfgRows,
  input  logic                startCube,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inData,
  output logic                inReady,
  output logic                outValid,
  input  logic                outReady,
  output logic [SAMPLE_W-1:0] outCur,
  output logic [SAMPLE_W-1:0] outPrev,
  output logic                outFirstPlane,
  output logic                outEndPlane,
  output logic                outEndCube
);
  ppg_strobe_t       strobe;
  logic [ADDR_W-1:0] addr;

  ppg_ctrl #(.MAX_COLS(MAX_COLS), .MAX_BANDS(MAX_BANDS), .ROW_W(ROW_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cfgCols       (cfgCols),
    .cfgBands      (cfgBands),
    .cfgRows       (cfgRows),
    .startCube     (startCube),
    .inValid       (inValid),
    .inReady       (inReady),
    .outReady      (outReady),
    .outValid      (outValid),
    .outFirstPlane (outFirstPlane),
    .outEndPlane   (outEndPlane),
    .outEndCube    (outEndCube),
    .strobe        (strobe),
    .addr          (addr)
  );

  ppg_datapath #(.SAMPLE_W(SAMPLE_W), .MAX_COLS(MAX_COLS), .MAX_BANDS(MAX_BANDS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addr    (addr),
    .inData  (inData),
    .outCur  (outCur),
    .outPrev (outPrev)
  );

  assert_first_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFirstPlane) |-> (outPrev == '0));

  assert_endcube_endplane_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEndCube) |-> outEndPlane);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outCur) && $stable(outPrev)
      && $stable({outFirstPlane, outEndPlane, outEndCube})));

  assert_accept_out_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outValid && outCur == $past(inData)));
endmodule

// File: tb/tb_plane_pair_grabber.sv
`timescale 1ns/1ps
module tb_plane_pair_grabber;
  localparam int SW = 16, MC = 8, MB = 4, RW = 4;
  localparam int CW = $clog2(MC + 1), BW = $clog2(MB + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic [CW-1:0] cfgCols = CW'(MC);
  logic [BW-1:0] cfgBands = BW'(MB);
  logic [RW-1:0] cfgRows = RW'(2);
  logic startCube = 1'b0, inValid = 1'b0, outReady = 1'b0;
  logic [SW-1:0] inData = '0;
  logic inReady, outValid, outFirstPlane, outEndPlane, outEndCube;
  logic [SW-1:0] outCur, outPrev;

  always #4 clk = ~clk;  // 125 MHz

  plane_pair_grabber #(.SAMPLE_W(SW), .MAX_COLS(MC), .MAX_BANDS(MB), .ROW_W(RW)) dut (
    .clk(clk), .rstN(rstN), .cfgCols(cfgCols), .cfgBands(cfgBands), .cfgRows(cfgRows),
    .startCube(startCube), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outCur(outCur), .outPrev(outPrev),
    .outFirstPlane(outFirstPlane), .outEndPlane(outEndPlane), .outEndCube(outEndCube));

  typedef struct packed {
    logic [SW-1:0] cur;
    logic [SW-1:0] prev;
    logic first, endP, endC;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  bit done = 0;
  int mCols = MC, mBands = MB, mRows = 2;
  int mc = 0, mb = 0, mr = 0;
  bit mFirst = 1;
  logic [SW-1:0] mStore [MB][MC];
  bit prevStall = 0, prevAcc = 0;
  logic [2*SW+2:0] snap;
  logic [SW-1:0] nextData;
  bit havePending = 0;
  int sentCnt = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t modelAccept(input logic [SW-1:0] d);
    exp_t e;
    e.cur   = d;
    e.prev  = mFirst ? '0 : mStore[mb][mc];
    e.first = mFirst;
    e.endP  = (mc == mCols - 1) && (mb == mBands - 1);
    e.endC  = e.endP && (mRows != 0) && (mr == mRows - 1);
    mStore[mb][mc] = d;
    if (mc != mCols - 1) mc++;
    else begin
      mc = 0;
      if (mb != mBands - 1) mb++;
      else begin
        mb = 0;
        if (mRows != 0 && mr == mRows - 1) begin mr = 0; mFirst = 1; end
        else begin mr++; mFirst = 0; end
      end
    end
    return e;
  endfunction

  // Called before each rising edge, once inputs have settled.
  task automatic monitor();
    exp_t e;
    logic [2*SW+2:0] now;
    now = {outCur, outPrev, outFirstPlane, outEndPlane, outEndCube};
    if (prevStall) begin
      check(outValid == 1'b1, "R8 valid held", 64'(outValid), 64'd1);
      check(now == snap, "R8 data held", 64'(now), 64'(snap));
    end
    if (prevAcc) check(outValid == 1'b1, "R10 valid after accept", 64'(outValid), 64'd1);
    if (outValid && !outReady) check(inReady == 1'b0, "R8 inReady low on stall", 64'(inReady), 64'd0);
    if (startCube) check(inReady == 1'b0, "R9 inReady low on start", 64'(inReady), 64'd0);
    if (outReady && !startCube) check(inReady == 1'b1, "R10 full rate ready", 64'(inReady), 64'd1);
    if (outValid && outReady) begin
      if (q.size() == 0) check(1'b0, "R2 unexpected output", 64'(outCur), 64'd0);
      else begin
        e = q.pop_front();
        check(outCur == e.cur, "R2 current sample", 64'(outCur), 64'(e.cur));
        check(outPrev == e.prev, e.first ? "R4 zero previous" : "R3 previous sample", 64'(outPrev), 64'(e.prev));
        check(outFirstPlane == e.first, "R4 first plane flag", 64'(outFirstPlane), 64'(e.first));
        check(outEndPlane == e.endP, "R5 end of plane", 64'(outEndPlane), 64'(e.endP));
        check(outEndCube == e.endC, mRows == 0 ? "R7 no end of cube" : "R6 end of cube", 64'(outEndCube), 64'(e.endC));
      end
    end
    prevAcc = inValid && inReady;
    if (prevAcc) q.push_back(modelAccept(inData));
    if (startCube) begin mc = 0; mb = 0; mr = 0; mFirst = 1; end
    prevStall = outValid && !outReady;
    snap = now;
  endtask

  task automatic runCycle(input bit offer, input bit rdy, input bit start);
    @(negedge clk);
    if (offer && !havePending) begin nextData = SW'($urandom); havePending = 1; end
    cfgCols = CW'(mCols); cfgBands = BW'(mBands); cfgRows = RW'(mRows);
    inValid = offer; inData = nextData; outReady = rdy; startCube = start;
    #2;
    monitor();
    if (inValid && inReady) begin havePending = 0; sentCnt++; end
  endtask

  task automatic stream(input int n, input int vPct, input int rPct);
    sentCnt = 0;
    while (sentCnt < n) runCycle(($urandom % 100) < vPct, ($urandom % 100) < rPct, 1'b0);
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && (outValid || q.size() != 0); i++) runCycle(1'b0, 1'b1, 1'b0);
    check(q.size() == 0, "R2 all samples delivered", 64'(q.size()), 64'd0);
  endtask

  task automatic newCube(input int c, input int b, input int r);
    mCols = c; mBands = b; mRows = r;
    runCycle(1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    check(outValid == 1'b0, "R1 reset outValid", 64'(outValid), 64'd0);
    check(inReady == 1'b1, "R1 reset inReady", 64'(inReady), 64'd1);
    // R1: first cube right after reset, no start pulse; full throughput (R10)
    stream(MC * MB * 2, 100, 100);
    drain();
    // R3 R5 R6: odd shape, two cubes back to back with random gaps and backpressure
    newCube(5, 3, 3);
    stream(5 * 3 * 3 * 2, 70, 60);
    drain();
    // R8: heavy backpressure
    newCube(MC, MB, 2);
    stream(MC * MB * 2, 90, 20);
    drain();
    // R9: start in mid plane while an output is stalled
    newCube(4, 2, 3);
    stream(11, 100, 100);
    runCycle(1'b1, 1'b0, 1'b0);
    runCycle(1'b1, 1'b0, 1'b1);
    newCube(3, 2, 2);
    stream(3 * 2 * 2, 80, 70);
    drain();
    // R7: unbounded cube
    newCube(2, 2, 0);
    stream(2 * 2 * 6, 80, 80);
    drain();
    // degenerate one-by-one plane
    newCube(1, 1, 4);
    stream(8, 60, 60);
    drain();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule